// File: doc/BRIEF.md
# Pulse-Width DAC Output Bank

The block produces fourteen pulse-width modulated outputs for low-rate analog control. An external RC filter turns each output into a voltage. Every channel has its own 8-bit duty register on a simple synchronous write bus with a combinational read port. All channels share one free-running period counter clocked by the crystal clock. A global period-select bit sets the period to either 253 or 256 clocks.

A channel's output is high while the shared count is below the channel's duty code, with the count measured from the start of the period. Each duty register is copied into a per-channel working value only at the period boundary, so a write never cuts a period short. The pads are open-drain: `pad_low` set means the pad pulls the line low, and clear means it releases the line.

The four highest channels can each be handed to a general-purpose port bit by clearing that channel's pin-enable bit in the control register.

Top module: `pwmbank_top`

## Requirements
- R1: Duty registers for channels 0..13 sit at bus addresses 20h..2Dh, channel n at 20h+n. They are 8 bits wide, are written when `wr_en` is high on a rising clock edge, read back on `rd_data` combinationally from `addr`, and reset to 80h.
- R2: The control register sits at address 2Eh and resets to 00h. Bit 0 is the period select: 1 gives 253 clocks, 0 gives 256. Bits 4..1 are the pin enables for channels 10..13, with bit 1 belonging to channel 10. It reads back with bits 7..5 as zero.
- R3: One shared counter runs 0..P-1, with P = 253 or 256. A channel is high in a period while the count is below its working duty code. Over one period the high time equals the code and the period equals P.
- R4: With the 253-clock period, codes FDh, FEh and FFh give an output that never goes low.
- R5: With the 256-clock period, code FFh gives exactly one low clock per period.
- R6: Code 00h gives an output that never goes high, in either period mode.
- R7: A duty write takes effect only when the counter wraps to 0. Until then the previous code still shapes the current period.
- R8: For channel 10+k (k = 0..3), when its pin enable is 0, `pad_low[10+k]` equals the inverse of `gpio_out[k]` in the same cycle. When the enable is 1, the pad carries the PWM output.
- R9: `pad_low[n]` is 1 exactly when channel n is low. The output for count value c appears one clock after the counter holds c. After reset every PWM pad pulls low.
- R10: Writes to addresses outside 20h..2Eh change no register, and reads from such addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| gpio_out | input | 4 | Port bits for channels 10..13 when released from PWM |
| pad_low | output | 14 | Per-pad pull-low request (1 = drive low, 0 = release) |

## Verification
A duty write and the period-boundary reload can land on the same clock. The reload must then take the old code, and the new code waits a full period. A change of period mode can also land while the count is already past 252, and the counter must then wrap at once. The bench issues writes at many phases of the period, including writes timed off the observed start of a period and a mode switch late in a 256-clock period. A behavioural reference model with its own counter, working values and register copy is stepped every clock, and every pad and the read port are compared against it on every cycle.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
  localparam int DUTY_W     = 8;
  localparam logic [DUTY_W-1:0] DUTY_RESET = 8'h80;
endpackage

// File: rtl/pwmbank_timebase.sv
module pwmbank_timebase
  import pwmbank_pkg::*;
#(
  parameter int SHORT_PERIOD = 253
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              short_mode,
  output logic [DUTY_W-1:0] cnt_q,
  output logic              wrap
);
  localparam int LONG_PERIOD = 1 << DUTY_W;
  localparam logic [DUTY_W-1:0] LAST_LONG  = DUTY_W'(LONG_PERIOD - 1);
  localparam logic [DUTY_W-1:0] LAST_SHORT = DUTY_W'(SHORT_PERIOD - 1);

  logic [DUTY_W-1:0] cnt_d;
  logic [DUTY_W-1:0] last;

  // A mode switch late in a long period wraps at once (>= rather than ==).
  always_comb begin
    last  = short_mode ? LAST_SHORT : LAST_LONG;
    wrap  = (cnt_q >= last);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwmbank_chan.sv
module pwmbank_chan
  import pwmbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] cnt,
  input  logic [DUTY_W-1:0] duty_reg,
  output logic [DUTY_W-1:0] active_q,
  output logic              high_q
);
  logic [DUTY_W-1:0] active_d;
  logic              high_d;

  always_comb begin
    active_d = wrap ? duty_reg : active_q;
    high_d   = (cnt < active_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= DUTY_RESET;
      high_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      high_q   <= high_d;
    end
  end
endmodule

// File: rtl/pwmbank_regs.sv
module pwmbank_regs
  import pwmbank_pkg::*;
#(
  parameter int NUM_CH     = 14,
  parameter int NUM_SHARED = 4,
  parameter int AW         = 8,
  parameter int BASE_ADDR  = 'h20,
  parameter int CTRL_ADDR  = 'h2E
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  addr,
  input  logic [DUTY_W-1:0]              wr_data,
  output logic [DUTY_W-1:0]              rd_data,
  output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_q,
  output logic                           short_mode,
  output logic [NUM_SHARED-1:0]          pin_en
);
  localparam int CTRL_W = NUM_SHARED + 1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_duty
      logic              we;
      logic [DUTY_W-1:0] duty_d;
      always_comb begin
        we     = wr_en && (addr == AW'(BASE_ADDR + g));
        duty_d = we ? wr_data : duty_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) duty_q[g] <= DUTY_RESET;
        else        duty_q[g] <= duty_d;
      end
    end
  endgenerate

  always_comb begin
    ctrl_we = wr_en && (addr == AW'(CTRL_ADDR));
    ctrl_d  = ctrl_we ? wr_data[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign short_mode = ctrl_q[0];
  assign pin_en     = ctrl_q[CTRL_W-1:1];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == AW'(BASE_ADDR + i)) rd_data = duty_q[i];
    end
    if (addr == AW'(CTRL_ADDR)) rd_data = DUTY_W'(ctrl_q);
  end
endmodule

// File: rtl/pwmbank_top.sv
module pwmbank_top
  import pwmbank_pkg::*;
#(
  parameter int NUM_CH       = 14,
  parameter int NUM_SHARED   = 4,
  parameter int AW           = 8,
  parameter int BASE_ADDR    = 'h20,
  parameter int CTRL_ADDR    = 'h2E,
  parameter int SHORT_PERIOD = 253
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [DUTY_W-1:0]     wr_data,
  output logic [DUTY_W-1:0]     rd_data,
  input  logic [NUM_SHARED-1:0] gpio_out,
  output logic [NUM_CH-1:0]     pad_low
);
  localparam int FIRST_SHARED = NUM_CH - NUM_SHARED;

  logic [NUM_CH-1:0][DUTY_W-1:0] duty_q;
  logic [NUM_CH-1:0][DUTY_W-1:0] active_q;
  logic [NUM_CH-1:0]             pwm_high;
  logic [DUTY_W-1:0]             cnt_q;
  logic                          wrap;
  logic                          short_mode;
  logic [NUM_SHARED-1:0]         pin_en;

  pwmbank_regs #(
    .NUM_CH(NUM_CH), .NUM_SHARED(NUM_SHARED), .AW(AW),
    .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .duty_q(duty_q),
    .short_mode(short_mode), .pin_en(pin_en)
  );

  pwmbank_timebase #(.SHORT_PERIOD(SHORT_PERIOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .short_mode(short_mode),
    .cnt_q(cnt_q), .wrap(wrap)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      pwmbank_chan u_chan (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt_q),
        .duty_reg(duty_q[g]), .active_q(active_q[g]), .high_q(pwm_high[g])
      );
      if (g < FIRST_SHARED) begin : g_fixed
        assign pad_low[g] = ~pwm_high[g];
      end else begin : g_shared
        localparam int K = g - FIRST_SHARED;
        assign pad_low[g] = pin_en[K] ? ~pwm_high[g] : ~gpio_out[K];
      end
    end
  endgenerate
endmodule

// File: rtl/pwmbank_chk.sv
module pwmbank_chk
  import pwmbank_pkg::*;
#(
  parameter int NUM_CH       = 14,
  parameter int SHORT_PERIOD = 253
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [DUTY_W-1:0]             cnt,
  input logic                          mode253,
  input logic [NUM_CH-1:0][DUTY_W-1:0] active,
  input logic [NUM_CH-1:0]             pwm_high
);
  localparam logic [DUTY_W-1:0] LAST_SHORT = DUTY_W'(SHORT_PERIOD - 1);
  localparam logic [DUTY_W-1:0] ALL_ONES   = '1;

  AST_LONG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == ALL_ONES) |-> (cnt == '0)); // R3

  AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode253 && cnt == LAST_SHORT) |-> (cnt == '0)); // R3

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(active)); // R7

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      AST_ZERO_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active[g] == '0) |-> !pwm_high[g]); // R6

      AST_SHORT_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode253 && cnt <= LAST_SHORT && active[g] > LAST_SHORT) |-> pwm_high[g]); // R4

      AST_LONG_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode253 && cnt == ALL_ONES) |-> !pwm_high[g]); // R5
    end
  endgenerate
endmodule

bind pwmbank_top pwmbank_chk #(.NUM_CH(NUM_CH), .SHORT_PERIOD(SHORT_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .mode253(short_mode),
  .active(active_q), .pwm_high(pwm_high)
);

// File: tb/tb_pwmbank_top.sv
module tb_pwmbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [3:0] gpio_out;
  logic [13:0] pad_low;

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  // behavioural reference state
  int m_cnt;
  int m_act [NCH];
  int m_reg [NCH];
  bit m_mode;
  bit [3:0] m_en;
  bit [13:0] m_high;

  pwmbank_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .gpio_out(gpio_out), .pad_low(pad_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_en = '0; m_high = '0;
      for (int i = 0; i < NCH; i++) begin m_act[i] = 128; m_reg[i] = 128; end
      started = 1;
    end else begin
      bit [13:0] nh;
      int last;
      for (int i = 0; i < NCH; i++) nh[i] = (m_cnt < m_act[i]);
      last = m_mode ? 252 : 255;
      if (m_cnt >= last) begin
        m_cnt = 0;
        for (int i = 0; i < NCH; i++) m_act[i] = m_reg[i];
      end else m_cnt++;
      m_high = nh;
      if (wr_en) begin
        if (addr >= 8'h20 && addr <= 8'h2D) m_reg[addr - 8'h20] = wr_data;
        else if (addr == 8'h2E) begin m_mode = wr_data[0]; m_en = wr_data[4:1]; end
      end
    end
  end

  function automatic string tag_of(input int i);
    if (i >= 10 && !m_en[i-10]) return "R8";
    if (m_act[i] == 0) return "R6";
    if (m_mode && m_act[i] >= 253) return "R4";
    if (!m_mode && m_act[i] == 255) return "R5";
    return "R9";
  endfunction

  function automatic int exp_rd(input logic [7:0] a);
    if (a >= 8'h20 && a <= 8'h2D) return m_reg[a - 8'h20];
    if (a == 8'h2E) return {3'b000, m_en, m_mode};
    return 0;
  endfunction

  // cycle-by-cycle comparison, sampled a quarter period after the edge
  always @(posedge clk) begin
    if (started) begin
      #(CLK_PERIOD/4);
      for (int i = 0; i < NCH; i++) begin
        bit e;
        e = (i >= 10 && !m_en[i-10]) ? ~gpio_out[i-10] : ~m_high[i];
        check(pad_low[i] == e, $sformatf("%s pad %0d", tag_of(i), i), pad_low[i], e);
      end
      check(rd_data == exp_rd(addr),
            (addr == 8'h2E) ? "R2 readback" :
            (addr >= 8'h20 && addr <= 8'h2D) ? "R1 readback" : "R10 readback",
            rd_data, exp_rd(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); addr = a; #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (!pad_low[ch]) h++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int h, per;
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h20; wr_data = '0; gpio_out = 4'b0000;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    check(pad_low == 14'h3FFF, "R9 reset pads", pad_low, 14'h3FFF);
    rd_chk(8'h20, 8'h80, "R1 reset duty ch0");
    rd_chk(8'h2D, 8'h80, "R1 reset duty ch13");
    rd_chk(8'h2E, 8'h00, "R2 reset ctrl");

    wr(8'h2E, 8'h1E);                    // all shared pins to PWM, 256 mode
    wr(8'h20, 8'h40); wr(8'h21, 8'hFF); wr(8'h22, 8'h00); wr(8'h23, 8'hFD);
    idle(520);
    count_high(0, 256, h); check(h == 64,  "R3 ch0 high count 256", h, 64);
    count_high(1, 256, h); check(h == 255, "R5 ch1 one low per period", h, 255);
    count_high(2, 256, h); check(h == 0,   "R6 ch2 never high", h, 0);

    wr(8'h2E, 8'h1F);                    // 253 mode
    idle(520);
    count_high(3, 253, h); check(h == 253, "R4 ch3 FDh never low", h, 253);
    count_high(1, 253, h); check(h == 253, "R4 ch1 FFh never low", h, 253);
    count_high(2, 253, h); check(h == 0,   "R6 ch2 never high 253", h, 0);
    count_high(0, 253, h); check(h == 64,  "R3 ch0 high count 253", h, 64);
    // period length between rising edges of ch0
    @(negedge pad_low[0]); per = 0;
    @(posedge pad_low[0]);
    while (pad_low[0]) @(negedge clk);
    @(negedge pad_low[0]);
    per = 0;
    fork
      begin
        @(posedge clk);
        per = 1;
        while (pad_low[0] == 1'b0 || per < 3) begin @(posedge clk); per++; #(CLK_PERIOD/4); if (pad_low[0]) break; end
        while (pad_low[0]) begin @(posedge clk); per++; #(CLK_PERIOD/4); end
      end
    join
    check(per == 253, "R3 period 253", per, 253);

    // R7: write right after a period start; old code must still hold
    @(negedge pad_low[0]);
    wr(8'h25, 8'h00);
    idle(5);
    check(pad_low[5] == 1'b0, "R7 old code kept mid-period", pad_low[5], 0);
    idle(300);
    check(pad_low[5] == 1'b1, "R7 new code after boundary", pad_low[5], 1);

    // writes at many phases, including boundary cycles
    for (int k = 0; k < 40; k++) begin
      wr(8'h26, 8'(k * 7));
      idle(k % 9);
    end
    // mode switch late in a long period
    wr(8'h2E, 8'h1E); idle(300);
    wr(8'h2E, 8'h1F); idle(300);

    // R8: release shared pins to port bits
    wr(8'h2E, 8'h01);
    gpio_out = 4'b0101; @(negedge clk); #1;
    check(pad_low[13:10] == 4'b1010, "R8 gpio pattern A", pad_low[13:10], 4'b1010);
    gpio_out = 4'b1010; @(negedge clk); #1;
    check(pad_low[13:10] == 4'b0101, "R8 gpio pattern B", pad_low[13:10], 4'b0101);
    wr(8'h2E, 8'h05); idle(260);        // only ch11 back to PWM
    rd_chk(8'h2E, 8'h05, "R2 ctrl readback");

    // R10: unmapped address
    wr(8'h50, 8'h33);
    wr(8'h1F, 8'h44);
    rd_chk(8'h50, 8'h00, "R10 unmapped read");
    rd_chk(8'h1F, 8'h00, "R10 unmapped read below");
    rd_chk(8'h20, 8'h40, "R1 ch0 unchanged");
    rd_chk(8'h2E, 8'h05, "R10 ctrl unchanged");
    idle(300);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule